// File: doc/BRIEF.md
# Power Management Control and Status Register

This block is the 32-bit power management control and status word of a bus-attached network function. Software reaches it through a simple register port with a byte address, write data, a write strobe and a combinational read path. The word holds the function's present power state, a wake-event status flag that software clears by writing one, a wake enable and a read/write data-select field. The other fields are fixed at zero.

Internal wake detection logic raises `wake_evt` for one cycle per event. The active-low `wake_n` output requests a wake-up whenever a recorded event and the enable are both set. The wake flag and the enable belong to their own reset domain. When the `cold_wake_cap` strap is high, only the power-up reset clears them and a warm reset leaves them alone. When the strap is low, every reset clears them. Power-state writes that ask for a state the build does not support complete normally, but the state stays unchanged.

Top module: `pm_csr`

## Requirements
- R1: While `por_rst` is high, at the next clock the whole word reads 0x00000000, `pwr_state` is 00 and `wake_n` is 1.
- R2: Bits 1:0 hold the power state, with 00 = D0, 01 = D1, 10 = D2 and 11 = D3hot. A write of a supported code takes effect at the next clock and shows on `pwr_state` and on read-back.
- R3: D0 and D3hot are always supported. D1 and D2 are supported only when parameters `HAS_D1` and `HAS_D2` are set. A write carrying an unsupported code leaves the power state unchanged, and the other fields of that same write still take effect.
- R4: A cycle with `wake_evt` high sets the wake flag (bit 15) at the next clock, whatever the value of the enable.
- R5: A write with bit 15 = 1 clears the wake flag. A write with bit 15 = 0 leaves the flag unchanged.
- R6: When a wake event and a clearing write fall in the same cycle, the flag ends up set.
- R7: Bit 8 is a read/write wake enable. `wake_n` is 0 exactly when the wake flag and the enable are both 1.
- R8: Bits 12:9 form a read/write select field that resets to 0000. Bits 31:16, 14:13 and 7:2 always read as 0, whatever is written to them.
- R9: With `cold_wake_cap` = 1, a warm reset clears the power state and the select field but keeps the wake flag and the enable. A wake event arriving during the warm reset still sets the flag.
- R10: With `cold_wake_cap` = 0, a warm reset also clears the wake flag and the enable.
- R11: Writes are ignored in a cycle where `warm_rst` is high. A read returns the value the word held before any write in the same cycle.
- R12: Only word address `CSR_ADDR` (compared on bits 7:2) is decoded. A write to any other address has no effect, and a read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-up reset, synchronous, active high |
| warm_rst | input | 1 | Hardware or software reset, synchronous, active high |
| cold_wake_cap | input | 1 | Strap: wake bits survive warm reset when high |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| wake_evt | input | 1 | Wake event pulse from internal detection |
| wake_n | output | 1 | Active-low wake request |
| pwr_state | output | 2 | Current power state code |

## Verification
The bench targets a wake event that lands in the same cycle as a clearing write. A design that lets the clear win loses that event and reads bit 15 as 0. It writes the unsupported D2 code together with a new enable value. A design that drops the whole write, or stores the code, shows the wrong state or the wrong enable. It applies warm resets with the strap set both ways: the wake bits must survive in one case and be cleared in the other. It also writes ones into the fixed-zero fields and into unmapped addresses, where any leakage appears in the read-back data.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [1:0] {
        PS_D0    = 2'b00,
        PS_D1    = 2'b01,
        PS_D2    = 2'b10,
        PS_D3HOT = 2'b11
    } pwr_state_e;

    localparam int WORD_W   = 32;
    localparam int SEL_W    = 4;
    localparam int BIT_STS  = 15;
    localparam int BIT_EN   = 8;
    localparam int SEL_LO   = 9;

    typedef struct packed {
        logic [15:0]      zero_hi;
        logic             wake_sts;
        logic [1:0]       scale;
        logic [SEL_W-1:0] sel;
        logic             wake_en;
        logic [5:0]       zero_lo;
        pwr_state_e       state;
    } csr_word_t;

    typedef struct packed {
        logic             hit;
        logic             sts_clr;
        logic             en_val;
        logic [SEL_W-1:0] sel_val;
        logic [1:0]       state_val;
    } csr_wr_t;

    function automatic logic state_ok(logic [1:0] code, logic d1_ok, logic d2_ok);
        case (code)
            2'b01:   return d1_ok;
            2'b10:   return d2_ok;
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/pm_state_reg.sv
module pm_state_reg
    import pm_pkg::*;
#(
    parameter bit HAS_D1 = 1'b1,
    parameter bit HAS_D2 = 1'b0
) (
    input  logic       clk,
    input  logic       por_rst,
    input  logic       warm_rst,
    input  csr_wr_t    wr,
    output pwr_state_e state
);

    logic accept;

    always_comb accept = wr.hit && state_ok(wr.state_val, HAS_D1, HAS_D2);

    always_ff @(posedge clk) begin
        if (por_rst || warm_rst)
            state <= PS_D0;
        else if (accept)
            state <= pwr_state_e'(wr.state_val);
    end

    AST_STATE_DROP: assert property (@(posedge clk) disable iff (por_rst)
        (!warm_rst && wr.hit && !state_ok(wr.state_val, HAS_D1, HAS_D2)) |=> $stable(state)); // R3

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (por_rst)
        state_ok(state, HAS_D1, HAS_D2)); // R3

    AST_WARM_STATE: assert property (@(posedge clk) disable iff (por_rst)
        warm_rst |=> (state == PS_D0)); // R9

endmodule

// File: rtl/pm_select_reg.sv
module pm_select_reg
    import pm_pkg::*;
(
    input  logic             clk,
    input  logic             por_rst,
    input  logic             warm_rst,
    input  csr_wr_t          wr,
    output logic [SEL_W-1:0] sel
);

    always_ff @(posedge clk) begin
        if (por_rst || warm_rst)
            sel <= '0;
        else if (wr.hit)
            sel <= wr.sel_val;
    end

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (por_rst || warm_rst)
        !wr.hit |=> $stable(sel)); // R8

endmodule

// File: rtl/pm_wake_reg.sv
module pm_wake_reg
    import pm_pkg::*;
(
    input  logic    clk,
    input  logic    por_rst,
    input  logic    warm_rst,
    input  logic    cold_wake_cap,
    input  logic    wake_evt,
    input  csr_wr_t wr,
    output logic    wake_sts,
    output logic    wake_en
);

    logic dom_rst;

    always_comb dom_rst = por_rst || (warm_rst && !cold_wake_cap);

    always_ff @(posedge clk) begin
        if (dom_rst)
            wake_sts <= 1'b0;
        else if (wake_evt)
            wake_sts <= 1'b1;
        else if (wr.hit && wr.sts_clr)
            wake_sts <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (dom_rst)
            wake_en <= 1'b0;
        else if (wr.hit)
            wake_en <= wr.en_val;
    end

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (por_rst)
        (wake_evt && !(warm_rst && !cold_wake_cap)) |=> wake_sts); // R4

    AST_CLR_WORKS: assert property (@(posedge clk) disable iff (por_rst)
        (wr.hit && wr.sts_clr && !wake_evt) |=> !wake_sts); // R5

    AST_SET_WINS: assert property (@(posedge clk) disable iff (por_rst)
        (wr.hit && wr.sts_clr && wake_evt) |=> wake_sts); // R6

    AST_WARM_KEEP: assert property (@(posedge clk) disable iff (por_rst)
        (warm_rst && cold_wake_cap && !wake_evt) |=> ($stable(wake_sts) && $stable(wake_en))); // R9

    AST_WARM_CLEAR: assert property (@(posedge clk) disable iff (por_rst)
        (warm_rst && !cold_wake_cap) |=> (!wake_sts && !wake_en)); // R10

endmodule

// File: rtl/pm_csr.sv
module pm_csr
    import pm_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter logic [7:0]  CSR_ADDR = 8'h44,
    parameter bit          HAS_D1   = 1'b1,
    parameter bit          HAS_D2   = 1'b0
) (
    input  logic              clk,
    input  logic              por_rst,
    input  logic              warm_rst,
    input  logic              cold_wake_cap,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              wake_evt,
    output logic              wake_n,
    output logic [1:0]        pwr_state
);

    localparam int WORD_LSB = 2;

    logic             addr_hit;
    csr_wr_t          wr;
    pwr_state_e       state_q;
    logic [SEL_W-1:0] sel_q;
    logic             sts_q;
    logic             en_q;
    csr_word_t        word;

    always_comb begin
        addr_hit     = (reg_addr[ADDR_W-1:WORD_LSB] == CSR_ADDR[ADDR_W-1:WORD_LSB]);
        wr.hit       = addr_hit && reg_wr && !warm_rst;
        wr.sts_clr   = reg_wdata[BIT_STS];
        wr.en_val    = reg_wdata[BIT_EN];
        wr.sel_val   = reg_wdata[SEL_LO +: SEL_W];
        wr.state_val = reg_wdata[1:0];
    end

    pm_state_reg #(
        .HAS_D1 (HAS_D1),
        .HAS_D2 (HAS_D2)
    ) u_state (
        .clk      (clk),
        .por_rst  (por_rst),
        .warm_rst (warm_rst),
        .wr       (wr),
        .state    (state_q)
    );

    pm_select_reg u_sel (
        .clk      (clk),
        .por_rst  (por_rst),
        .warm_rst (warm_rst),
        .wr       (wr),
        .sel      (sel_q)
    );

    pm_wake_reg u_wake (
        .clk           (clk),
        .por_rst       (por_rst),
        .warm_rst      (warm_rst),
        .cold_wake_cap (cold_wake_cap),
        .wake_evt      (wake_evt),
        .wr            (wr),
        .wake_sts      (sts_q),
        .wake_en       (en_q)
    );

    always_comb begin
        word          = '0;
        word.wake_sts = sts_q;
        word.sel      = sel_q;
        word.wake_en  = en_q;
        word.state    = state_q;
        reg_rdata     = addr_hit ? word : '0;
        wake_n        = !(sts_q && en_q);
        pwr_state     = state_q;
    end

    AST_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (por_rst || warm_rst)
        (!addr_hit && !wake_evt) |=> ($stable(pwr_state) && $stable(wake_n))); // R12

    AST_POR_IDLE: assert property (@(posedge clk)
        por_rst |=> (wake_n && pwr_state == 2'b00)); // R1

endmodule

// File: tb/test_pm_csr.sv
`timescale 1ns/1ps
module test_pm_csr;

    localparam logic [7:0] A_CSR = 8'h44;

    logic        clk = 1'b0;
    logic        por_rst, warm_rst, cold_wake_cap;
    logic [7:0]  reg_addr;
    logic        reg_wr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        wake_evt;
    logic        wake_n;
    logic [1:0]  pwr_state;

    int checks = 0;
    int errors = 0;

    logic [1:0] m_ps;
    logic [3:0] m_sel;
    logic       m_st, m_en;

    always #10 clk = ~clk;

    pm_csr i_pm_csr (
        .clk(clk), .por_rst(por_rst), .warm_rst(warm_rst), .cold_wake_cap(cold_wake_cap),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wake_evt(wake_evt), .wake_n(wake_n), .pwr_state(pwr_state)
    );

    function automatic logic [31:0] exp_word(logic [1:0] ps, logic [3:0] sel, logic st, logic en);
        return {16'h0, st, 2'b00, sel, en, 6'h0, ps};
    endfunction

    function automatic logic supported(logic [1:0] c);
        return (c != 2'b10);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_outputs(string tag);
        logic [31:0] e;
        e = (reg_addr[7:2] == A_CSR[7:2]) ? exp_word(m_ps, m_sel, m_st, m_en) : 32'h0;
        chk({tag, " R11 rdata"}, reg_rdata, e);
        chk({tag, " R7 wake_n"}, {31'h0, wake_n}, {31'h0, !(m_st && m_en)});
        chk({tag, " R2 pwr_state"}, {30'h0, pwr_state}, {30'h0, m_ps});
    endtask

    task automatic step(string tag, logic [7:0] a, logic w, logic [31:0] d,
                        logic ev, logic wr_rst, logic pr);
        logic hit;
        @(negedge clk);
        reg_addr = a; reg_wr = w; reg_wdata = d; wake_evt = ev; warm_rst = wr_rst; por_rst = pr;
        #2;
        if (!pr) check_outputs(tag);
        @(posedge clk);
        hit = (a[7:2] == A_CSR[7:2]) && w && !wr_rst;
        if (pr || (wr_rst && !cold_wake_cap)) begin m_st = 0; m_en = 0; end
        else begin
            if (ev) m_st = 1'b1; else if (hit && d[15]) m_st = 1'b0;
            if (hit) m_en = d[8];
        end
        if (pr || wr_rst) begin m_ps = 0; m_sel = 0; end
        else if (hit) begin
            m_sel = d[12:9];
            if (supported(d[1:0])) m_ps = d[1:0];
        end
    endtask

    task automatic idle(string tag);
        step(tag, A_CSR, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic power_up(logic cap);
        cold_wake_cap = cap;
        step("por", A_CSR, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b1);
        step("por", A_CSR, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1);
        @(negedge clk); #2;
        chk("R1 reset word", reg_rdata, 32'h0);
        chk("R1 reset wake_n", {31'h0, wake_n}, 32'h1);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        por_rst = 1; warm_rst = 0; cold_wake_cap = 1; reg_addr = 0; reg_wr = 0;
        reg_wdata = 0; wake_evt = 0;
        m_ps = 0; m_sel = 0; m_st = 0; m_en = 0;
        power_up(1'b1);

        // R2: every supported code, R3: D2 dropped while enable/select still land
        step("R2 D3hot", A_CSR, 1, 32'h3, 0, 0, 0);
        step("R2 D1", A_CSR, 1, 32'h1, 0, 0, 0);
        step("R3 D2 drop", A_CSR, 1, 32'h0000_1502, 0, 0, 0);
        idle("R3 after drop");
        chk("R3 state kept", {30'h0, pwr_state}, 32'h1);
        // R8: ones into fixed fields
        step("R8 ones", A_CSR, 1, 32'hFFFF_7EFF, 0, 0, 0);
        idle("R8 readback");
        // R4: event with enable clear
        step("R4 en off", A_CSR, 1, 32'h0, 0, 0, 0);
        step("R4 evt", A_CSR, 0, 32'h0, 1, 0, 0);
        idle("R4 after");
        chk("R4 flag", {31'h0, reg_rdata[15]}, 32'h1);
        // R5: write 0 keeps, write 1 clears
        step("R5 zero", A_CSR, 1, 32'h100, 0, 0, 0);
        idle("R5 kept");
        chk("R5 kept flag", {31'h0, reg_rdata[15]}, 32'h1);
        chk("R7 asserted", {31'h0, wake_n}, 32'h0);
        step("R5 one", A_CSR, 1, 32'h8100, 0, 0, 0);
        idle("R5 cleared");
        // R6: collision
        step("R6 both", A_CSR, 1, 32'h8100, 1, 0, 0);
        idle("R6 after");
        chk("R6 set wins", {31'h0, reg_rdata[15]}, 32'h1);
        // R12: other address
        step("R12 miss", 8'h48, 1, 32'h8003, 0, 0, 0);
        step("R12 miss rd", 8'h48, 0, 32'h0, 0, 0, 0);
        idle("R12 after");
        // R9: warm reset keeps wake bits with strap high; write during reset ignored (R11)
        step("R9 warm", A_CSR, 1, 32'h8003, 0, 1, 0);
        idle("R9 after");
        chk("R9 wake kept", {31'h0, wake_n}, 32'h0);

        // R10: strap low
        power_up(1'b0);
        step("R10 set en", A_CSR, 1, 32'h103, 1, 0, 0);
        idle("R10 armed");
        step("R10 warm", A_CSR, 0, 32'h0, 0, 1, 0);
        idle("R10 after");
        chk("R10 cleared", reg_rdata, 32'h0);

        // random phases, both strap values
        for (int ph = 0; ph < 2; ph++) begin
            power_up(ph[0]);
            for (int i = 0; i < 1500; i++) begin
                logic [7:0] a;
                a = ($urandom % 4 != 0) ? A_CSR : 8'($urandom);
                step("rand", a, 1'($urandom % 2), $urandom,
                     ($urandom % 5 == 0), ($urandom % 40 == 0), 1'b0);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule